// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block keeps the pending-interrupt flags for two timer/counters in one 8-bit register that the CPU can read and write. Four event strobes come in from the timer logic: timer1 overflow, timer1 compare match, timer1 input capture and timer0 overflow. Each strobe sets its own flag. A flag stays set until software writes a one to its bit, or until the CPU takes that source's interrupt vector and pulses the matching acknowledge line.

Each source raises its interrupt request only when three things are true: the global interrupt enable is on, the source's enable bit is set, and its flag is set. When timer1 runs as a PWM, its overflow flag is taken from a separate strobe that marks the counter leaving 0x0000, and the normal wrap strobe is not used. The counters, the compare and capture logic, and the vector logic all sit outside this block.

Each flag is a two-state machine. In `FLG_IDLE` the flag is clear. A set strobe moves it to `FLG_PEND`. It goes back from `FLG_PEND` to `FLG_IDLE` when a clear arrives in a cycle with no set strobe. In every other case it keeps its state.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset, every flag reads 0 and every interrupt request is low, even when the global enable and all source enables are 1.
- R2: Register layout:
  - bit 7 is the timer1 overflow flag;
  - bit 6 is the timer1 compare flag;
  - bit 3 is the timer1 capture flag;
  - bit 1 is the timer0 overflow flag;
  - bits 5, 4, 2 and 0 always read 0, including after a write of ones to them.
- R3: Writing a 1 to a flag bit clears that flag. Writing a 0 to a flag bit leaves it unchanged.
- R4: A pulse on `vec_ack_i[k]` clears flag k. The source index k is 0 for timer0 overflow, 1 for timer1 capture, 2 for timer1 compare and 3 for timer1 overflow.
- R5: `irq_o[k]` is high in exactly those cycles in which `gie_i`, `src_en_i[k]` and flag k are all 1. It follows changes to the enables in the same cycle.
- R6: With `t1_pwm_i` = 0, the timer1 overflow flag is set by `t1_wrap_i`, and `t1_leave_zero_i` is ignored. With `t1_pwm_i` = 1, the flag is set by `t1_leave_zero_i`, and `t1_wrap_i` is ignored.
- R7: An event strobe that is high at a clock edge makes its flag read 1 from the next cycle. This holds for the capture strobe too, so the capture flag is set in step with the capture register load.
- R8: If a set strobe and a clear (by write or by acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R9: In the cycle of a write, `reg_rdata_o` shows the flag values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| t1_wrap_i | input | 1 | Timer1 wrap strobe (non-PWM overflow) |
| t1_leave_zero_i | input | 1 | Timer1 leaves 0x0000 strobe (PWM overflow) |
| t1_pwm_i | input | 1 | Timer1 is in PWM mode |
| t1_match_i | input | 1 | Timer1 compare-match strobe |
| t1_capture_i | input | 1 | Timer1 input-capture strobe |
| t0_wrap_i | input | 1 | Timer0 overflow strobe |
| src_en_i | input | 4 | Per-source interrupt enables, indexed as in R4 |
| gie_i | input | 1 | Global interrupt enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data; a 1 clears the flag at that bit |
| reg_rdata_o | output | 8 | Register read value |
| vec_ack_i | input | 4 | Per-source vector-taken pulses, indexed as in R4 |
| irq_o | output | 4 | Per-source interrupt requests, indexed as in R4 |

## Verification
The bench goes after the following corner cases:
- **Set and clear in the same cycle.** A set strobe arrives with a write-one or an acknowledge to the same flag. A design where the clear wins would silently lose the event.
- **Write of zeros and writes to reserved bits.** A design that copies write data into the register would set flags, or make reserved bits read back as 1.
- **Timer1 overflow source selection.** The bench pulses the inactive overflow strobe in each timer1 mode. A design with the mux inverted, or one that ORs the two strobes, raises a false overflow.
- **Reads during a write-one-to-clear.** Reads that land on the cycle of a clearing write catch a design that exposes the post-write value.
- **Enable timing.** Toggling the enables in the middle of a cycle catches a request path that was registered instead of combinational.

// File: rtl/tif_pkg.sv
`timescale 1ns/1ps
package tif_pkg;
    localparam int NSRC  = 4;
    localparam int REG_W = 8;

    localparam int SRC_T0_OVF = 0;
    localparam int SRC_T1_CAP = 1;
    localparam int SRC_T1_CMP = 2;
    localparam int SRC_T1_OVF = 3;

    // register bit that holds the flag of source k
    function automatic int flag_pos(input int k);
        case (k)
            0:       return 1;
            1:       return 3;
            2:       return 6;
            default: return 7;
        endcase
    endfunction

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_t;
endpackage

// File: rtl/tif_event_sel.sv
`timescale 1ns/1ps
module tif_event_sel
    import tif_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         t1_wrap_i,
    input  logic         t1_leave_zero_i,
    input  logic         t1_pwm_i,
    input  logic         t1_match_i,
    input  logic         t1_capture_i,
    input  logic         t0_wrap_i,
    output logic [N-1:0] set_o
);
    logic t1_ovf_evt;

    // PWM mode counts overflow as the counter leaving bottom, not the wrap
    always_comb begin
        t1_ovf_evt = t1_pwm_i ? t1_leave_zero_i : t1_wrap_i;
    end

    always_comb begin
        set_o             = '0;
        set_o[SRC_T0_OVF] = t0_wrap_i;
        set_o[SRC_T1_CAP] = t1_capture_i;
        set_o[SRC_T1_CMP] = t1_match_i;
        set_o[SRC_T1_OVF] = t1_ovf_evt;
    end
endmodule

// File: rtl/tif_flag_cell.sv
`timescale 1ns/1ps
module tif_flag_cell
    import tif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_t st_q;
    flag_state_t st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLG_IDLE: if (set_i)           st_d = FLG_PEND;
            FLG_PEND: if (clr_i && !set_i) st_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLG_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        flag_o = (st_q == FLG_PEND);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o); // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o); // R3
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_o)); // R3
endmodule

// File: rtl/tif_reg_port.sv
`timescale 1ns/1ps
module tif_reg_port
    import tif_pkg::*;
#(
    parameter int N = NSRC,
    parameter int W = REG_W
) (
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [N-1:0] ack_i,
    input  logic [N-1:0] flags_i,
    output logic [N-1:0] clr_o,
    output logic [W-1:0] rdata_o
);
    for (genvar k = 0; k < N; k++) begin : g_clr
        localparam int P = flag_pos(k);
        assign clr_o[k] = (wr_i && wdata_i[P]) || ack_i[k];
    end

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < N; k++) begin
            rdata_o[flag_pos(k)] = flags_i[k];
        end
    end
endmodule

// File: rtl/tif_req_gate.sv
`timescale 1ns/1ps
module tif_req_gate #(
    parameter int N = 4
) (
    input  logic         gie_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] flags_i,
    output logic [N-1:0] irq_o
);
    always_comb begin
        irq_o = {N{gie_i}} & en_i & flags_i;
    end
endmodule

// File: rtl/tmr_irq_flags.sv
`timescale 1ns/1ps
module tmr_irq_flags
    import tif_pkg::*;
#(
    parameter int REG_BITS = REG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                t1_wrap_i,
    input  logic                t1_leave_zero_i,
    input  logic                t1_pwm_i,
    input  logic                t1_match_i,
    input  logic                t1_capture_i,
    input  logic                t0_wrap_i,
    input  logic [NSRC-1:0]     src_en_i,
    input  logic                gie_i,
    input  logic                reg_wr_i,
    input  logic [REG_BITS-1:0] reg_wdata_i,
    output logic [REG_BITS-1:0] reg_rdata_o,
    input  logic [NSRC-1:0]     vec_ack_i,
    output logic [NSRC-1:0]     irq_o
);
    localparam logic [REG_BITS-1:0] RSVD_MASK = 8'h35;

    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] flags;

    tif_event_sel #(.N(NSRC)) u_evt (
        .t1_wrap_i       (t1_wrap_i),
        .t1_leave_zero_i (t1_leave_zero_i),
        .t1_pwm_i        (t1_pwm_i),
        .t1_match_i      (t1_match_i),
        .t1_capture_i    (t1_capture_i),
        .t0_wrap_i       (t0_wrap_i),
        .set_o           (set_vec)
    );

    for (genvar k = 0; k < NSRC; k++) begin : g_cell
        tif_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[k]),
            .clr_i  (clr_vec[k]),
            .flag_o (flags[k])
        );

        AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[k] |-> (reg_rdata_o[flag_pos(k)] && gie_i)); // R5
        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (vec_ack_i[k] && !set_vec[k]) |=> !reg_rdata_o[flag_pos(k)]); // R4
    end

    tif_reg_port #(.N(NSRC), .W(REG_BITS)) u_port (
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .ack_i   (vec_ack_i),
        .flags_i (flags),
        .clr_o   (clr_vec),
        .rdata_o (reg_rdata_o)
    );

    tif_req_gate #(.N(NSRC)) u_gate (
        .gie_i   (gie_i),
        .en_i    (src_en_i),
        .flags_i (flags),
        .irq_o   (irq_o)
    );

    AST_PWM_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_pwm_i && t1_leave_zero_i) |=> reg_rdata_o[7]); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && ((reg_wdata_i & RSVD_MASK) != '0)) |=> ((reg_rdata_o & RSVD_MASK) == '0)); // R2
endmodule

// File: tb/tmr_irq_flags_tb.sv
`timescale 1ns/1ps
module tmr_irq_flags_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       t1w = 0, t1z = 0, pwm = 0, t1m = 0, t1c = 0, t0w = 0;
    logic [3:0] en = 4'hF;
    logic       gie = 1'b1;
    logic       wr = 0;
    logic [7:0] wdata = 0;
    logic [3:0] ack = 0;
    logic [7:0] rdata;
    logic [3:0] irq;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;
    bit  mf [4];

    always #2 clk = ~clk;

    tmr_irq_flags dut_i (
        .clk(clk), .rst_n(rst_n),
        .t1_wrap_i(t1w), .t1_leave_zero_i(t1z), .t1_pwm_i(pwm),
        .t1_match_i(t1m), .t1_capture_i(t1c), .t0_wrap_i(t0w),
        .src_en_i(en), .gie_i(gie),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .vec_ack_i(ack), .irq_o(irq)
    );

    function automatic int pos(input int k);
        int p [4] = '{1, 3, 6, 7};
        return p[k];
    endfunction

    function automatic logic [7:0] exp_rdata();
        logic [7:0] r = 8'h00;
        for (int k = 0; k < 4; k++) r[pos(k)] = mf[k];
        return r;
    endfunction

    function automatic logic [3:0] exp_irq();
        logic [3:0] q;
        for (int k = 0; k < 4; k++) q[k] = gie & en[k] & mf[k];
        return q;
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (rdata !== exp_rdata()) begin
            fails++;
            $display("FAIL %s rdata actual %h expected %h", tag, rdata, exp_rdata());
        end
        checks++;
        if (irq !== exp_irq()) begin
            fails++;
            $display("FAIL %s irq actual %b expected %b", tag, irq, exp_irq());
        end
    endtask

    // inputs are applied at a negedge; outputs checked 1 ns later, model advanced at posedge
    task automatic step(input string tag);
        logic [3:0] s;
        #1;
        compare(tag);
        @(posedge clk);
        s[0] = t0w; s[1] = t1c; s[2] = t1m; s[3] = pwm ? t1z : t1w;
        for (int k = 0; k < 4; k++) begin
            if (s[k]) mf[k] = 1'b1;
            else if ((wr && wdata[pos(k)]) || ack[k]) mf[k] = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        t1w = 0; t1z = 0; t1m = 0; t1c = 0; t0w = 0;
        wr = 0; wdata = 0; ack = 0;
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-reqs actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) mf[k] = 0;
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        quiet(); step("R1 after reset");

        // R7 / R2: each source sets its own bit, next cycle
        t1c = 1; step("R7 capture strobe"); quiet(); step("R7 capture visible");
        t1m = 1; step("R2 compare"); quiet(); step("R2 compare bit");
        t0w = 1; step("R2 t0 ovf"); quiet(); step("R2 t0 bit");
        t1w = 1; step("R2 t1 ovf"); quiet(); step("R2 t1 bit");

        // R3: writing zero keeps flags; R9 read shows pre-write value
        wr = 1; wdata = 8'h00; step("R3 write zero"); quiet(); step("R3 kept");
        wr = 1; wdata = 8'h40; step("R9 read during clear"); quiet(); step("R3 one bit cleared");
        // R2: write to reserved bits only
        wr = 1; wdata = 8'h35; step("R2 reserved write"); quiet(); step("R2 reserved read zero");
        wr = 1; wdata = 8'hFF; step("R9 clear all"); quiet(); step("R3 all cleared");

        // R6: mode selection for timer1 overflow
        pwm = 0; t1z = 1; step("R6 leave-zero ignored"); quiet(); step("R6 no flag");
        pwm = 1; t1w = 1; step("R6 wrap ignored in pwm"); quiet(); step("R6 no flag pwm");
        t1z = 1; step("R6 pwm leave-zero"); quiet(); step("R6 pwm flag");
        pwm = 0;

        // R4: acknowledge clears one flag at a time
        t0w = 1; t1c = 1; t1m = 1; step("R4 set all"); quiet(); step("R4 all set");
        for (int k = 0; k < 4; k++) begin
            ack[k] = 1; step("R4 ack"); quiet(); step("R4 acked");
        end

        // R8: set and clear collide
        t1m = 1; wr = 1; wdata = 8'h40; step("R8 set vs write"); quiet(); step("R8 kept set");
        t1m = 1; ack = 4'b0100; step("R8 set vs ack"); quiet(); step("R8 kept set ack");

        // R5: gating combinations
        t0w = 1; t1c = 1; t1w = 1; step("R5 set"); quiet();
        gie = 0; step("R5 gie off");
        gie = 1; en = 4'b0101; step("R5 partial en");
        en = 4'b0000; step("R5 no en");
        en = 4'hF; step("R5 all en");

        // random mix of everything
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom;
            t1w = r[0]; t1z = r[1]; pwm = r[2]; t1m = r[3] & r[4];
            t1c = r[5] & r[6]; t0w = r[7] & r[8]; en = r[12:9];
            gie = r[13] | r[14]; wr = r[15]; wdata = r[23:16];
            ack = r[27:24] & {4{r[28]}};
            step("R5 R8 random");
        end
        quiet();
        step("R3 random end");

        done = 1;
        summary();
        $finish;
    end
endmodule